// File: doc/BRIEF.md
# Packed Float-to-Integer Converter

This unit takes a 64-bit word carrying two IEEE-754 single-precision numbers and turns each one into a two's-complement 32-bit integer. Each result sits in the same half of the output word that its source held in the input. A 2-bit rounding selector chooses how fractional values are resolved. The selector is applied to both lanes on every transfer.

Two status flags come out with the packed result. Invalid marks any lane whose value cannot be expressed as a signed 32-bit integer. Precision marks any lane that lost a nonzero fraction. An unexpressible lane always yields the integer-indefinite word 0x80000000. The block only reports these conditions. Trapping, masking, operand fetch and register writeback belong to the surrounding datapath.

A transfer is accepted when `in_valid` is high. Its result appears exactly one clock later with `out_valid` high. When no transfer is accepted, the outputs hold their previous values.

Top module: `fcvt_pk2i`

## Requirements
- R1: Input bits 31:0 convert into output bits 31:0, and input bits 63:32 convert into output bits 63:32. The two lanes are independent, and an exact integer input is returned unchanged with no flags.
- R2: `out_valid` equals `in_valid` of the previous clock. A synchronous active-high `rst` clears `out_valid`, `out_data` and both flags.
- R3: Rounding code 00 rounds to nearest, with ties going to the even integer (2.5 gives 2, 1.5 gives 2, -2.5 gives -2).
- R4: Rounding code 01 rounds toward negative infinity (-1.5 gives -2).
- R5: Rounding code 10 rounds toward positive infinity (1.5 gives 2, -1.5 gives -1).
- R6: Rounding code 11 truncates toward zero (-2.5 gives -2).
- R7: A NaN (exponent all ones, fraction nonzero) or an infinity gives lane result 0x80000000 and sets Invalid.
- R8: A value whose rounded magnitude lies outside the range -2^31 to 2^31-1 gives 0x80000000 and sets Invalid. The largest float below 2^31 is still converted exactly.
- R9: An input that rounds to exactly -2^31 is representable. It returns 0x80000000 without setting Invalid.
- R10: A zero of either sign gives 0 with no flags. A lane that is Invalid does not contribute to Precision.
- R11: Denormals and magnitudes below one produce 0 or ±1, according to the rounding mode and the sign, and set Precision.
- R12: Each output flag is the OR of the two lanes' conditions.
- R13: While `in_valid` is low, `out_data` and both flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept an operand this cycle |
| in_data | input | 64 | Two single-precision lanes; the low lane is in bits 31:0 |
| in_rmode | input | 2 | Rounding: 00 nearest-even, 01 down, 10 up, 11 toward zero |
| out_valid | output | 1 | Result of the previous cycle's transfer is present |
| out_data | output | 64 | Two packed signed 32-bit results |
| out_invalid | output | 1 | At least one lane was unrepresentable |
| out_inexact | output | 1 | At least one valid lane was rounded |

## Verification
Invalid and Precision can both be raised in the same cycle when they come from different lanes. That case exercises the per-lane suppression of Precision and the OR that merges the flags. It is provoked by vectors that pair a NaN or an out-of-range value in one lane with a fractional value in the other. The bench checks that both flags are high, that the bad lane carries 0x80000000, and that the other lane carries its correctly rounded value. Companion vectors put the NaN beside an exact integer, and there Precision must stay low.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
   typedef enum logic [1:0] {
      RM_NEAR = 2'b00,
      RM_DOWN = 2'b01,
      RM_UP   = 2'b10,
      RM_ZERO = 2'b11
   } rmode_e;
endpackage

// File: rtl/fcvt_round.sv
module fcvt_round (
   input  logic            sgn,
   input  fcvt_pkg::rmode_e rmode,
   input  logic            lsb,
   input  logic            rbit,
   input  logic            sticky,
   output logic            inc
);
   import fcvt_pkg::*;
   always_comb begin
      unique case (rmode)
         RM_NEAR: inc = rbit & (sticky | lsb);
         RM_DOWN: inc = (rbit | sticky) & sgn;
         RM_UP:   inc = (rbit | sticky) & ~sgn;
         default: inc = 1'b0;
      endcase
   end
endmodule

// File: rtl/fcvt_lane.sv
module fcvt_lane #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter int INT_W = 32
) (
   input  logic [EXP_W+MAN_W:0] fp,
   input  fcvt_pkg::rmode_e     rmode,
   output logic [INT_W-1:0]     res,
   output logic                 invalid,
   output logic                 inexact
);
   localparam int FP_W   = 1 + EXP_W + MAN_W;
   localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
   localparam int MAX_SH = INT_W - 2;
   localparam int SH_W   = MAN_W + 1 + MAX_SH;
   localparam int IP_W   = SH_W - MAN_W;

   if (EXP_W < 2) begin : g_bad_exp
      $error("fcvt_lane: EXP_W must be at least 2");
   end
   if (MAN_W >= INT_W - 1) begin : g_bad_man
      $error("fcvt_lane: MAN_W must be below INT_W-1");
   end

   logic                 sgn;
   logic [EXP_W-1:0]     ex;
   logic [MAN_W-1:0]     fr;
   logic [MAN_W:0]       mant;
   logic [SH_W-1:0]      fix;
   logic [IP_W-1:0]      ipart;
   logic                 rbit, sticky, inc;
   logic                 pre_inv, pre_zero, pre_min;
   logic [INT_W-1:0]     mag;
   int                   ue;

   assign sgn  = fp[FP_W-1];
   assign ex   = fp[FP_W-2:MAN_W];
   assign fr   = fp[MAN_W-1:0];
   assign mant = {|ex, fr};

   always_comb begin
      ue       = int'(ex) - BIAS;
      fix      = '0;
      ipart    = '0;
      rbit     = 1'b0;
      sticky   = 1'b0;
      pre_inv  = 1'b0;
      pre_zero = 1'b0;
      pre_min  = 1'b0;
      if (&ex) begin
         pre_inv = 1'b1;
      end else if (ex == '0 && fr == '0) begin
         pre_zero = 1'b1;
      end else if (ue > MAX_SH) begin
         if (ue == INT_W - 1 && sgn && fr == '0) pre_min = 1'b1;
         else                                    pre_inv = 1'b1;
      end else if (ue >= 0) begin
         fix    = SH_W'(mant) << unsigned'(ue);
         ipart  = fix[SH_W-1:MAN_W];
         rbit   = fix[MAN_W-1];
         sticky = |fix[MAN_W-2:0];
      end else if (ue == -1) begin
         rbit   = 1'b1;
         sticky = |fr;
      end else begin
         sticky = 1'b1;
      end
   end

   fcvt_round u_round (
      .sgn    (sgn),
      .rmode  (rmode),
      .lsb    (ipart[0]),
      .rbit   (rbit),
      .sticky (sticky),
      .inc    (inc)
   );

   always_comb begin
      mag     = INT_W'(ipart) + INT_W'(inc);
      invalid = pre_inv;
      if (mag[INT_W-1] && (!sgn || mag[INT_W-2:0] != '0)) invalid = 1'b1;
      inexact = (rbit | sticky) & ~invalid;
      if (invalid || pre_min)  res = {1'b1, {(INT_W-1){1'b0}}};
      else if (pre_zero)       res = '0;
      else if (sgn)            res = -mag;
      else                     res = mag;
   end
endmodule

// File: rtl/fcvt_pk2i.sv
module fcvt_pk2i #(
   parameter int LANES = 2,
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter int INT_W = 32
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         in_valid,
   input  logic [LANES*(1+EXP_W+MAN_W)-1:0] in_data,
   input  logic [1:0]                   in_rmode,
   output logic                         out_valid,
   output logic [LANES*INT_W-1:0]       out_data,
   output logic                         out_invalid,
   output logic                         out_inexact
);
   localparam int FP_W = 1 + EXP_W + MAN_W;

   if (LANES < 1) begin : g_bad_lanes
      $error("fcvt_pk2i: LANES must be at least 1");
   end

   logic [LANES*INT_W-1:0] lane_res;
   logic [LANES-1:0]       lane_inv;
   logic [LANES-1:0]       lane_inx;
   fcvt_pkg::rmode_e       rm;

   assign rm = fcvt_pkg::rmode_e'(in_rmode);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      fcvt_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_lane (
         .fp      (in_data[g*FP_W +: FP_W]),
         .rmode   (rm),
         .res     (lane_res[g*INT_W +: INT_W]),
         .invalid (lane_inv[g]),
         .inexact (lane_inx[g])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid   <= 1'b0;
         out_data    <= '0;
         out_invalid <= 1'b0;
         out_inexact <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data    <= lane_res;
            out_invalid <= |lane_inv;
            out_inexact <= |lane_inx;
         end
      end
   end
endmodule

// File: rtl/fcvt_pk2i_chk.sv
module fcvt_pk2i_chk #(
   parameter int LANES = 2,
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter int INT_W = 32
) (
   input logic                         clk,
   input logic                         rst,
   input logic                         in_valid,
   input logic [LANES*(1+EXP_W+MAN_W)-1:0] in_data,
   input logic                         out_valid,
   input logic [LANES*INT_W-1:0]       out_data,
   input logic                         out_invalid,
   input logic                         out_inexact
);
   localparam int FP_W = 1 + EXP_W + MAN_W;
   localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

   p_reset_clear_r2: assert property (@(posedge clk) rst |=> !out_valid);

   p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   p_valid_drop_r2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   p_hold_r13: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(out_data) && $stable(out_invalid) && $stable(out_inexact)));

   p_nan_inf_r7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (&in_data[FP_W-2:MAN_W]))
      |=> (out_invalid && out_data[INT_W-1:0] == INDEF));

   p_zero_r10: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_data[FP_W-2:0] == '0 && in_data[2*FP_W-2:FP_W] == '0)
      |=> (out_data == '0 && !out_invalid && !out_inexact));

   p_indef_r8: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_invalid)
      |-> (out_data[INT_W-1:0] == INDEF || out_data[2*INT_W-1:INT_W] == INDEF));
endmodule

bind fcvt_pk2i fcvt_pk2i_chk #(
   .LANES(LANES), .EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)
) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
   .out_valid(out_valid), .out_data(out_data),
   .out_invalid(out_invalid), .out_inexact(out_inexact)
);

// File: tb/test_fcvt_pk2i.sv
`timescale 1ns/1ps
module test_fcvt_pk2i;
   localparam real HALF = 2.5;

   typedef struct packed {
      logic [23:0] tag;
      logic [1:0]  rm;
      logic [63:0] din;
      logic [63:0] dout;
      logic        inv;
      logic        inx;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{"R1",  2'd3, 64'h42F60000_C2F60000, 64'h0000007B_FFFFFF85, 1'b0, 1'b0},
      '{"R3",  2'd0, 64'h40200000_3FC00000, 64'h00000002_00000002, 1'b0, 1'b1},
      '{"R3",  2'd0, 64'hC0200000_3F400000, 64'hFFFFFFFE_00000001, 1'b0, 1'b1},
      '{"R4",  2'd1, 64'h3FC00000_BFC00000, 64'h00000001_FFFFFFFE, 1'b0, 1'b1},
      '{"R5",  2'd2, 64'h3FC00000_BFC00000, 64'h00000002_FFFFFFFF, 1'b0, 1'b1},
      '{"R6",  2'd3, 64'hC0200000_40200000, 64'hFFFFFFFE_00000002, 1'b0, 1'b1},
      '{"R7",  2'd0, 64'h7FC00000_7F800001, 64'h80000000_80000000, 1'b1, 1'b0},
      '{"R7",  2'd2, 64'hFF800000_3F800000, 64'h80000000_00000001, 1'b1, 1'b0},
      '{"R8",  2'd0, 64'h4F000000_4EFFFFFF, 64'h80000000_7FFFFF80, 1'b1, 1'b0},
      '{"R8",  2'd2, 64'hCF000001_4F800000, 64'h80000000_80000000, 1'b1, 1'b0},
      '{"R9",  2'd3, 64'hCF000000_00000000, 64'h80000000_00000000, 1'b0, 1'b0},
      '{"R10", 2'd1, 64'h80000000_00000000, 64'h00000000_00000000, 1'b0, 1'b0},
      '{"R10", 2'd0, 64'h7FC00000_40000000, 64'h80000000_00000002, 1'b1, 1'b0},
      '{"R11", 2'd2, 64'h00000001_80000001, 64'h00000001_00000000, 1'b0, 1'b1},
      '{"R11", 2'd1, 64'h00000001_80000001, 64'h00000000_FFFFFFFF, 1'b0, 1'b1},
      '{"R11", 2'd0, 64'h3F000000_BF000000, 64'h00000000_00000000, 1'b0, 1'b1},
      '{"R12", 2'd0, 64'h3F800000_3FC00000, 64'h00000001_00000002, 1'b0, 1'b1},
      '{"R12", 2'd0, 64'h7FC00000_3FC00000, 64'h80000000_00000002, 1'b1, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [63:0] in_data = '0;
   logic [1:0]  in_rmode = '0;
   logic        out_valid;
   logic [63:0] out_data;
   logic        out_invalid, out_inexact;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(HALF) clk = ~clk;

   fcvt_pk2i i_fcvt_pk2i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_rmode(in_rmode), .out_valid(out_valid), .out_data(out_data),
      .out_invalid(out_invalid), .out_inexact(out_inexact)
   );

   task automatic check(input string req, input logic [65:0] got, input logic [65:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(2.0 * HALF * 5000.0);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      // reset state (R2)
      repeat (3) @(negedge clk);
      check("R2", {out_valid, out_invalid, out_inexact, 63'(out_data)}, '0);
      rst = 1'b0;
      @(negedge clk);
      check("R2", 66'(out_valid), 66'(0));

      // vector table, back to back
      for (int i = 0; i < NV; i++) begin
         in_valid = 1'b1;
         in_data  = VECS[i].din;
         in_rmode = VECS[i].rm;
         @(negedge clk);
         check(string'(VECS[i].tag), {out_data, out_invalid, out_inexact},
               {VECS[i].dout, VECS[i].inv, VECS[i].inx});
         check("R2", 66'(out_valid), 66'(1));
      end

      // idle: outputs hold (R13), valid drops (R2)
      in_valid = 1'b0;
      in_data  = 64'h7FC00000_7FC00000;
      in_rmode = 2'd1;
      @(negedge clk);
      check("R2", 66'(out_valid), 66'(0));
      @(negedge clk);
      check("R13", {out_data, out_invalid, out_inexact},
            {VECS[NV-1].dout, VECS[NV-1].inv, VECS[NV-1].inx});

      // one accepted transfer after idle (R1)
      in_valid = 1'b1;
      in_data  = 64'h3F800000_C2F60000;
      in_rmode = 2'd0;
      @(negedge clk);
      check("R1", {out_data, out_invalid, out_inexact}, {64'h00000001_FFFFFF85, 2'b00});

      // reset while a transfer is offered (R2)
      rst = 1'b1;
      @(negedge clk);
      check("R2", {out_valid, out_invalid, out_inexact, 63'(out_data)}, '0);
      rst = 1'b0;
      in_valid = 1'b0;
      @(negedge clk);
      check("R2", 66'(out_valid), 66'(0));

      finish_run();
   end
endmodule